// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block raises interrupts between the two ports of a shared two-port memory. The two highest word addresses of the memory act as mailboxes. The top address is the right port's inbox, and the address one below it is the left port's inbox. The block does not store the message word itself; the memory array holds it. The block only watches the access strobes of each port and keeps one interrupt flag per port.

When a port writes its partner's inbox, the partner's interrupt is raised. When the partner later reads its own inbox, its interrupt is cleared. A port that reads back the inbox it wrote into leaves the partner's interrupt untouched. The value written has no influence, because only the access decides the outcome.

The block samples the port controls on each rising clock edge. A flag changes on the edge that samples the qualifying access, and the active-low interrupt output follows that flag directly.

Top module: `dpram_mbox_irq`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `l_irq_n` and `r_irq_n` are high after that edge.
- R2: A left-port write (`l_ce_n`=0, `l_rw`=0) to the all-ones address drives `r_irq_n` low after the sampling edge.
- R3: A right-port read (`r_ce_n`=0, `r_rw`=1, `r_oe_n`=0) of the all-ones address drives `r_irq_n` high after the sampling edge, unless R8 applies.
- R4: A right-port write (`r_ce_n`=0, `r_rw`=0) to the all-ones address minus one drives `l_irq_n` low after the sampling edge.
- R5: A left-port read (`l_ce_n`=0, `l_rw`=1, `l_oe_n`=0) of the all-ones address minus one drives `l_irq_n` high after the sampling edge, unless R8 applies.
- R6: A left read of the all-ones address does not change `r_irq_n`. A right read of the all-ones address minus one does not change `l_irq_n`.
- R7: An access with chip enable high does nothing. A read with output enable high does not clear. A write (`rw`=0) never clears, whatever the level of output enable.
- R8: If a set and a clear of the same flag are sampled on the same edge, the flag ends up set (interrupt low).
- R9: Accesses to any other address leave both interrupts unchanged. With no qualifying access, both interrupts hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce_n | input | 1 | Left port chip enable, active low |
| l_rw | input | 1 | Left port direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | ADDR_W | Left port word address |
| r_ce_n | input | 1 | Right port chip enable, active low |
| r_rw | input | 1 | Right port direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | ADDR_W | Right port word address |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
Each flag sits directly behind its output pin, so a wrong flag state shows on that port's interrupt right after the edge that caused it. It stays visible until the next set or clear of that flag. A wrongly decoded access or a wrong priority therefore shows up in the same cycle that is compared. The bench builds its expected flags from the access rules and sweeps every control combination and every address on the left port, against mailbox and non-mailbox addresses on the right port. Every cycle is compared, so a divergence is caught at once and not only at the end.

// File: rtl/mbox_irq_pkg.sv
// Package: shared types for the mailbox interrupt controller.
// Assumes: controls of both ports use the same active-low encoding.
package mbox_irq_pkg;

    // Side index: which port a flag or decoder belongs to.
    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    // Control strobes of one port as seen on the pins.
    typedef struct packed {
        logic ce_n;   // chip enable, active low
        logic rw;     // 1 = read, 0 = write
        logic oe_n;   // output enable, active low
    } port_ctrl_t;

    // A read is only counted when enable, output enable and read level agree.
    function automatic logic is_read(port_ctrl_t c);
        return !c.ce_n && c.rw && !c.oe_n;
    endfunction

    // A write needs chip enable with the direction pin low.
    function automatic logic is_write(port_ctrl_t c);
        return !c.ce_n && !c.rw;
    endfunction

endpackage

// File: rtl/mbox_access_decode.sv
// Module: mbox_access_decode
// Classifies one port's access against the two mailbox addresses.
// rd_own  : the port reads its own inbox (a clear request for its flag).
// wr_peer : the port writes its partner's inbox (a set request for the partner).
// Assumes: the outputs are combinational and are registered by the flag module.
module mbox_access_decode
    import mbox_irq_pkg::*;
#(
    parameter int                ADDR_W   = 15,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '0,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  port_ctrl_t        ctrl,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_own,
    output logic              wr_peer
);

    // Decode the access type and match it against the mailbox addresses.
    always_comb begin
        rd_own  = is_read(ctrl)  && (addr == OWN_BOX);
        wr_peer = is_write(ctrl) && (addr == PEER_BOX);
    end

    // A deselected port can request nothing (R7).
    always_comb begin
        if (ctrl.ce_n) begin
            assert_deselect_quiet_R7: assert (!rd_own && !wr_peer)
                else $error("deselected port produced a mailbox request");
        end
    end

endmodule

// File: rtl/mbox_irq_flag.sv
// Module: mbox_irq_flag
// Holds one pending-interrupt flag. A set request wins over a clear
// request sampled on the same edge. Synchronous active-low reset clears it.
module mbox_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Update the flag: reset, then set, then clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o)
        else $error("flag not set after set request");

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o)
        else $error("flag not cleared after clear request");

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o))
        else $error("flag changed without request");

endmodule

// File: rtl/dpram_mbox_irq.sv
// Module: dpram_mbox_irq (top)
// Cross-port mailbox interrupts for a two-port memory. The all-ones word
// address is the right port's inbox and the address one below it is the
// left port's inbox. Writing the partner's inbox raises the partner's
// interrupt. Reading one's own inbox clears one's own interrupt.
// Assumes: port strobes are synchronous to clk; message storage is elsewhere.
module dpram_mbox_irq
    import mbox_irq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);

    localparam int                NSIDE  = 2;
    localparam logic [ADDR_W-1:0] BOX_R  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_L  = BOX_R - 1'b1;

    port_ctrl_t        ctrl    [NSIDE];
    logic [ADDR_W-1:0] addr    [NSIDE];
    logic              rd_own  [NSIDE];
    logic              wr_peer [NSIDE];
    logic              flag    [NSIDE];

    // Gather the pins of both ports into side-indexed arrays.
    always_comb begin
        ctrl[SIDE_L] = '{ce_n: l_ce_n, rw: l_rw, oe_n: l_oe_n};
        ctrl[SIDE_R] = '{ce_n: r_ce_n, rw: r_rw, oe_n: r_oe_n};
        addr[SIDE_L] = l_addr;
        addr[SIDE_R] = r_addr;
    end

    // One decoder and one flag per side; the partner's write sets the flag.
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam logic [ADDR_W-1:0] OWN  = (s == int'(SIDE_R)) ? BOX_R : BOX_L;
        localparam logic [ADDR_W-1:0] PEER = (s == int'(SIDE_R)) ? BOX_L : BOX_R;

        mbox_access_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) i_dec (
            .ctrl    (ctrl[s]),
            .addr    (addr[s]),
            .rd_own  (rd_own[s]),
            .wr_peer (wr_peer[s])
        );

        mbox_irq_flag i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (wr_peer[NSIDE-1-s]),
            .clr_i  (rd_own[s]),
            .flag_o (flag[s])
        );
    end

    // Drive the active-low interrupt pins straight from the flags.
    always_comb begin
        l_irq_n = !flag[SIDE_L];
        r_irq_n = !flag[SIDE_R];
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (l_irq_n && r_irq_n))
        else $error("interrupt active after reset");

    assert_left_sets_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && !l_rw && l_addr == BOX_R) |=> !r_irq_n)
        else $error("left write to right inbox did not interrupt right");

    assert_right_sets_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ce_n && !r_rw && r_addr == BOX_L) |=> !l_irq_n)
        else $error("right write to left inbox did not interrupt left");

    assert_left_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && l_rw && !l_oe_n && l_addr == BOX_L
         && !(!r_ce_n && !r_rw && r_addr == BOX_L)) |=> l_irq_n)
        else $error("left read of own inbox did not clear");

    assert_peer_read_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!l_ce_n && !l_rw && l_addr == BOX_R)
         && !(!r_ce_n && r_rw && !r_oe_n && r_addr == BOX_R)) |=> $stable(r_irq_n))
        else $error("right interrupt changed without a right-flag access");

endmodule

// File: tb/test_dpram_mbox_irq.sv
// Bench: drives inputs on the falling edge, compares on the next falling edge
// against flags computed from the access rules. Small 4-bit address space.
module test_dpram_mbox_irq;

    localparam int         AW  = 4;
    localparam logic [3:0] TOP = 4'hF;   // right inbox
    localparam logic [3:0] SUB = 4'hE;   // left inbox

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_ce_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1;
    logic r_ce_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit exp_l = 1'b0;  // expected pending flag for left
    bit exp_r = 1'b0;  // expected pending flag for right

    always #5 clk = ~clk;

    dpram_mbox_irq #(.ADDR_W(AW)) i_dpram_mbox_irq (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Apply one cycle: c = {ce_n, rw, oe_n}; update the model; return at negedge.
    task automatic step(input logic [2:0] lc, input logic [AW-1:0] la,
                        input logic [2:0] rc, input logic [AW-1:0] ra);
        bit l_wr, l_rd, r_wr, r_rd;
        {l_ce_n, l_rw, l_oe_n} = lc;  l_addr = la;
        {r_ce_n, r_rw, r_oe_n} = rc;  r_addr = ra;
        l_wr = !lc[2] && !lc[1];
        l_rd = !lc[2] &&  lc[1] && !lc[0];
        r_wr = !rc[2] && !rc[1];
        r_rd = !rc[2] &&  rc[1] && !rc[0];
        @(posedge clk);
        if (!rst_n) begin
            exp_l = 1'b0; exp_r = 1'b0;
        end else begin
            if (l_wr && la == TOP)      exp_r = 1'b1;
            else if (r_rd && ra == TOP) exp_r = 1'b0;
            if (r_wr && ra == SUB)      exp_l = 1'b1;
            else if (l_rd && la == SUB) exp_l = 1'b0;
        end
        @(negedge clk);
    endtask

    localparam logic [2:0] IDLE = 3'b111;
    localparam logic [2:0] WR   = 3'b001;
    localparam logic [2:0] RD   = 3'b010;

    initial begin
        @(negedge clk);
        step(IDLE, 0, IDLE, 0);
        check("R1 reset l_irq_n", l_irq_n, 1'b1);
        check("R1 reset r_irq_n", r_irq_n, 1'b1);
        rst_n = 1'b1;

        step(WR, TOP, IDLE, 0);
        check("R2 left write top", r_irq_n, 1'b0);
        check("R2 left irq untouched", l_irq_n, 1'b1);
        step(RD, TOP, IDLE, 0);
        check("R6 left read top keeps right irq", r_irq_n, 1'b0);
        step(IDLE, 0, 3'b011, TOP);
        check("R7 read without oe keeps right irq", r_irq_n, 1'b0);
        step(IDLE, 0, 3'b110, TOP);
        check("R7 read without ce keeps right irq", r_irq_n, 1'b0);
        step(IDLE, 0, 3'b000, TOP);
        check("R7 write with oe low keeps right irq", r_irq_n, 1'b0);
        step(IDLE, 0, RD, TOP);
        check("R3 right read top clears", r_irq_n, 1'b1);

        step(IDLE, 0, 3'b101, SUB);
        check("R7 write with ce high no set", l_irq_n, 1'b1);
        step(IDLE, 0, WR, SUB);
        check("R4 right write top-1", l_irq_n, 1'b0);
        step(IDLE, 0, RD, SUB);
        check("R6 right read top-1 keeps left irq", l_irq_n, 1'b0);
        step(IDLE, 0, IDLE, 0);
        check("R9 idle hold", l_irq_n, 1'b0);
        step(RD, SUB, IDLE, 0);
        check("R5 left read top-1 clears", l_irq_n, 1'b1);

        step(WR, TOP, RD, TOP);
        check("R8 set beats clear right", r_irq_n, 1'b0);
        step(RD, SUB, WR, SUB);
        check("R8 set beats clear left", l_irq_n, 1'b0);
        step(WR, 4'hD, WR, 4'h3);
        check("R9 other address left", l_irq_n, 1'b0);
        check("R9 other address right", r_irq_n, 1'b0);
        step(RD, 4'h0, RD, 4'hD);
        check("R9 other read left", l_irq_n, 1'b0);
        check("R9 other read right", r_irq_n, 1'b0);

        rst_n = 1'b0;
        step(IDLE, 0, IDLE, 0);
        check("R1 mid-run reset l_irq_n", l_irq_n, 1'b1);
        check("R1 mid-run reset r_irq_n", r_irq_n, 1'b1);
        rst_n = 1'b1;

        // Sweep: every left address and control against key right accesses (R6 R7 R8 R9).
        for (int la = 0; la < 16; la++) begin
            for (int lc = 0; lc < 8; lc++) begin
                for (int ri = 0; ri < 4; ri++) begin
                    for (int rc = 0; rc < 8; rc++) begin
                        logic [AW-1:0] ra;
                        ra = (ri == 0) ? TOP : (ri == 1) ? SUB : (ri == 2) ? 4'h0 : 4'h9;
                        step(3'(lc), 4'(la), 3'(rc), ra);
                        check("sweep l_irq_n (R5 R6 R7 R8 R9)", l_irq_n, !exp_l);
                        check("sweep r_irq_n (R2 R3 R6 R7 R8)", r_irq_n, !exp_r);
                    end
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule